// File: doc/BRIEF.md
# Deserializer Lock and Output Controller

This controller runs at the recovered word-clock rate beside a serial-to-parallel receiver. It moves the receiver through its life cycle: powered down, waiting for the local reference loop to settle, searching the serial input for word framing, locked, and a short forced hold after a lost boundary edge. From that state it derives an active-low lock indicator, a data-valid flag, the choice of clock source for the recovered clock (local reference or remote transmit clock), and the enables that stand in for the high-impedance control of the data, clock and lock pads.

A word aligner supplies a level flag that is high when framing is found, and a one-cycle pulse when an expected boundary edge was not seen. A reference-cycle tick paces the start-up wait. An output-enable input can switch off the data and clock drivers at any time without disturbing the state sequence. A strobe-select input picks whether downstream logic captures data on the rising or the falling recovered-clock edge.

Top module: `deser_lock_ctrl`

## Requirements
- R1: While `pwr_on` is sampled low, the next state is powered down and `dout_oe`, `rclk_oe`, `lock_oe`, `data_valid` and `clk_remote` are all 0; `lock_n` reads 1.
- R2: After the first clock edge that samples `pwr_on` high, the controller waits for REF_WAIT (default 2048) `ref_tick` pulses sampled on later edges; cycles without a tick do not count. During this wait `lock_oe` is 1, `lock_n` is 1, and `dout_oe` and `rclk_oe` are 0.
- R3: After the wait, while searching for framing, `dout_oe` and `rclk_oe` equal `out_en`, `clk_remote` is 0 (reference source) and `lock_n` stays 1.
- R4: When `framed` is sampled high while searching, `lock_n` is 0 and `clk_remote` is 1 (remote transmit clock) from the next cycle on.
- R5: `data_valid` is 0 in the first locked cycle (first selected strobe edge) and 1 from the second locked cycle on; it is 0 whenever `lock_n` is 1.
- R6: A `edge_miss` pulse sampled while locked makes `lock_n` 1, `clk_remote` 0 and `data_valid` 0 for exactly HOLD_MIN (default 2) cycles, whatever `framed` does; data and clock enables keep following `out_en`. A missed edge wins over `framed` in the same cycle.
- R7: At the end of the hold, `framed` sampled high relocks directly (R4, R5 timing again); `framed` low returns to searching.
- R8: With `out_en` low, `dout_oe` and `rclk_oe` are 0 while `lock_oe` stays 1 and `lock_n` keeps reporting input status; state timing is identical to the enabled case.
- R9: `strobe_rise` is copied to `strobe_pol`: 1 means data is captured on the rising recovered-clock edge, 0 on the falling edge.
- R10: Dropping `pwr_on` in any state clears all state and counters; its next rise restarts the full REF_WAIT wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_on | input | 1 | Power enable; low means power-down |
| out_en | input | 1 | Enable for data and clock drivers |
| strobe_rise | input | 1 | 1 selects rising strobe edge, 0 falling |
| framed | input | 1 | Aligner has found word framing |
| edge_miss | input | 1 | Aligner missed a boundary edge (pulse) |
| ref_tick | input | 1 | One pulse per reference-clock cycle |
| lock_n | output | 1 | Lock indicator, 0 = locked |
| data_valid | output | 1 | Parallel data valid |
| clk_remote | output | 1 | Recovered clock source: 1 remote, 0 reference |
| dout_oe | output | 1 | Data driver enable |
| rclk_oe | output | 1 | Recovered-clock driver enable |
| lock_oe | output | 1 | Lock driver enable |
| strobe_pol | output | 1 | Strobe polarity control, 1 = rising |

## Verification
The start-up wait is run once with a tick on every cycle and once with a tick on every other cycle, which separates counting ticks from counting clocks. Lock loss is tried with `framed` held high through the hold, which shows the hold is not cut short and that relock then follows at once, and with `framed` low, which shows the return to searching. Output enable is toggled while locked and while held, and power is dropped both mid-lock and mid-wait, so restart of the wait is told apart from a resumed count.

// File: rtl/deser_lock_ctrl.sv
module deser_lock_ctrl #(
  parameter int REF_WAIT = 2048,
  parameter int HOLD_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_on,
  input  logic out_en,
  input  logic strobe_rise,
  input  logic framed,
  input  logic edge_miss,
  input  logic ref_tick,
  output logic lock_n,
  output logic data_valid,
  output logic clk_remote,
  output logic dout_oe,
  output logic rclk_oe,
  output logic lock_oe,
  output logic strobe_pol
);

  localparam int WCW = $clog2(REF_WAIT + 1);
  localparam int HCW = $clog2(HOLD_MIN + 1);

  typedef enum logic [2:0] {S_OFF, S_WAIT, S_ACQ, S_LOCK, S_HOLD} st_t;

  st_t            st;
  logic [WCW-1:0] wcnt;
  logic [HCW-1:0] hcnt;
  logic           seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_OFF;
      wcnt <= '0;
      hcnt <= '0;
      seen <= 1'b0;
    end else if (!pwr_on) begin
      st   <= S_OFF;
      wcnt <= '0;
      hcnt <= '0;
      seen <= 1'b0;
    end else begin
      case (st)
        S_OFF: begin
          st   <= S_WAIT;
          wcnt <= '0;
        end
        S_WAIT: if (ref_tick) begin
          if (wcnt == WCW'(REF_WAIT - 1)) st <= S_ACQ;
          else wcnt <= wcnt + 1'b1;
        end
        S_ACQ: if (framed) begin
          st   <= S_LOCK;
          seen <= 1'b0;
        end
        S_LOCK: begin
          if (edge_miss) begin
            st   <= S_HOLD;
            hcnt <= '0;
            seen <= 1'b0;
          end else begin
            seen <= 1'b1;
          end
        end
        S_HOLD: begin
          if (hcnt == HCW'(HOLD_MIN - 1)) begin
            st   <= framed ? S_LOCK : S_ACQ;
            seen <= 1'b0;
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        default: st <= S_OFF;
      endcase
    end
  end

  logic drv_live;
  assign drv_live   = (st == S_ACQ) || (st == S_LOCK) || (st == S_HOLD);
  assign lock_n     = (st != S_LOCK);
  assign clk_remote = (st == S_LOCK);
  assign data_valid = (st == S_LOCK) && seen;
  assign lock_oe    = (st != S_OFF);
  assign dout_oe    = drv_live && out_en;
  assign rclk_oe    = drv_live && out_en;
  assign strobe_pol = strobe_rise;

  a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwr_on) |-> (!dout_oe && !rclk_oe && !lock_oe && !data_valid));

  a_r4_frame_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ACQ && framed && pwr_on) |=> (!lock_n && clk_remote));

  a_r5_first_edge_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_n) |-> !data_valid);

  a_r5_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (!lock_n && clk_remote));

  a_r8_lock_pad_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_oe || rclk_oe) |-> lock_oe);

  generate
    if (HOLD_MIN >= 2) begin : g_hold_chk
      a_r6_hold_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n) |=> lock_n);
    end
  endgenerate

endmodule

// File: tb/deser_lock_ctrl_tb.sv
module deser_lock_ctrl_tb;
  localparam int WAIT = 2048;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b0, out_en = 1'b1, strobe_rise = 1'b1;
  logic framed = 1'b0, edge_miss = 1'b0, ref_tick = 1'b0;
  logic tick_slow = 1'b0;
  logic lock_n, data_valid, clk_remote, dout_oe, rclk_oe, lock_oe, strobe_pol;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  deser_lock_ctrl #(.REF_WAIT(WAIT), .HOLD_MIN(HOLD)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .out_en(out_en),
    .strobe_rise(strobe_rise), .framed(framed), .edge_miss(edge_miss),
    .ref_tick(ref_tick), .lock_n(lock_n), .data_valid(data_valid),
    .clk_remote(clk_remote), .dout_oe(dout_oe), .rclk_oe(rclk_oe),
    .lock_oe(lock_oe), .strobe_pol(strobe_pol));

  // reference model: 0 off, 1 waiting, 2 searching, 3 locked, 4 holding
  int mph = 0, mticks = 0, mheld = 0, mlocked = 0;

  always @(posedge clk) begin
    if (!rst_n || !pwr_on) begin
      mph = 0; mticks = 0; mheld = 0; mlocked = 0;
    end else if (mph == 0) begin
      mph = 1; mticks = 0;
    end else if (mph == 1) begin
      if (ref_tick) mticks++;
      if (mticks == WAIT) mph = 2;
    end else if (mph == 2) begin
      if (framed) begin mph = 3; mlocked = 0; end
    end else if (mph == 3) begin
      if (edge_miss) begin mph = 4; mheld = 0; end
      else mlocked++;
    end else begin
      mheld++;
      if (mheld == HOLD) begin mph = framed ? 3 : 2; mlocked = 0; end
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [6:0] e;
      logic live;
      string tag;
      live = (mph >= 2);
      e = {mph != 3, mph == 3 && mlocked > 0, mph == 3,
           live && out_en, live && out_en, mph != 0, strobe_rise};
      case (mph)
        0: tag = "R1";
        1: tag = "R2";
        2: tag = "R3";
        3: tag = "R5";
        default: tag = "R6";
      endcase
      chk(tag, {lock_n, data_valid, clk_remote, dout_oe, rclk_oe, lock_oe, strobe_pol}, e);
    end
  end

  initial begin
    forever begin
      @(negedge clk); #1;
      ref_tick = tick_slow ? ~ref_tick : 1'b1;
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic one(string tag, logic act, logic exp);
    chk(tag, {6'b0, act}, {6'b0, exp});
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    one("R1 reset lock_oe", lock_oe, 1'b0);
    one("R1 reset dout_oe", dout_oe, 1'b0);
    // power up with a tick every cycle
    pwr_on = 1'b1;
    repeat (WAIT) @(posedge clk);
    @(negedge clk); #2;
    one("R2 still waiting", dout_oe, 1'b0);
    one("R2 lock pad live", lock_oe, 1'b1);
    step(1);
    one("R3 data pad on", dout_oe, 1'b1);
    one("R3 reference clock", clk_remote, 1'b0);
    // framing
    framed = 1'b1;
    step(1);
    one("R4 lock low", lock_n, 1'b0);
    one("R5 first edge invalid", data_valid, 1'b0);
    step(1);
    one("R5 second edge valid", data_valid, 1'b1);
    step(3);
    // missed edge with framing held high
    edge_miss = 1'b1;
    step(1);
    edge_miss = 1'b0;
    one("R6 hold lock high", lock_n, 1'b1);
    one("R6 hold reference clock", clk_remote, 1'b0);
    one("R6 hold pad on", dout_oe, 1'b1);
    step(1);
    one("R6 hold second cycle", lock_n, 1'b1);
    step(1);
    one("R7 relock", lock_n, 1'b0);
    one("R7 relock first invalid", data_valid, 1'b0);
    step(2);
    // output enable low while locked
    out_en = 1'b0;
    step(1);
    one("R8 data pad off", dout_oe, 1'b0);
    one("R8 clock pad off", rclk_oe, 1'b0);
    one("R8 lock still shown", lock_n, 1'b0);
    // missed edge with framing low and outputs off
    framed = 1'b0;
    edge_miss = 1'b1;
    step(1);
    edge_miss = 1'b0;
    step(2);
    one("R7 back to search", lock_n, 1'b1);
    out_en = 1'b1;
    step(1);
    one("R8 re-enabled", rclk_oe, 1'b1);
    strobe_rise = 1'b0;
    step(1);
    one("R9 falling strobe", strobe_pol, 1'b0);
    strobe_rise = 1'b1;
    framed = 1'b1;
    step(4);
    // power down mid lock, restart with slower ticks
    pwr_on = 1'b0;
    step(2);
    one("R10 pads off", lock_oe, 1'b0);
    tick_slow = 1'b1;
    pwr_on = 1'b1;
    step(WAIT + 20);
    one("R2 slow ticks still waiting", dout_oe, 1'b0);
    // drop power mid wait, then full restart
    pwr_on = 1'b0;
    step(2);
    pwr_on = 1'b1;
    tick_slow = 1'b0;
    step(WAIT - 10);
    one("R10 wait restarted", dout_oe, 1'b0);
    step(30);
    one("R4 relock after restart", lock_n, 1'b0);
    step(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule